// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block holds the status and protection state of a small serial EEPROM. It keeps the write-enable latch, the busy flag and three nonvolatile settings: a hardware-pin enable bit and a two-bit block-protect code. Nonvolatile storage is modelled as registers with a reset value. The serial front end sends it one-cycle strobes: set latch, clear latch, array write request (with the target address), status write request (with a data byte) and write-cycle done. The hardware write-protect pin is also an input. The block returns the 8-bit status value and a same-cycle permit for each write request.

When a request is permitted, the front end starts its self-timed write cycle and the block reports busy until the front end signals that the cycle is done. Completion clears the write-enable latch. If the completed cycle was a status write, the new protection settings are stored at that point. Requests are judged against the state held at the start of the cycle. A request that arrives in the same cycle as the done strobe therefore still sees the device as busy.

Top module: `status_guard`

## Requirements
- R1: With no write in progress, `statusOut` bit 7 is the pin-enable bit, bits 6..4 read 0, bit 3 is the high protect bit, bit 2 is the low protect bit, bit 1 is the write-enable latch and bit 0 is 0.
- R2: After reset, the latch is clear, no write is in progress and the nonvolatile bits take `NV_INIT` (default 0), so `statusOut` reads 0x00.
- R3: With no write in progress, `latchSet` sets the write-enable latch and `latchClr` clears it, both visible in `statusOut` bit 1 after the next clock edge.
- R4: `latchSet` and `latchClr` have no effect while a write is in progress.
- R5: `writePermit` is high in the same cycle as an array write request only if the latch is set, no write is in progress and the address is unprotected.
- R6: The protect code selects the protected addresses: 00 protects none, 01 the top quarter (0x300–0x3FF), 10 the top half (0x200–0x3FF), 11 the whole array.
- R7: A refused array write starts no cycle and leaves the write-enable latch unchanged.
- R8: A status write is permitted only if the latch is set and no write is in progress. It is also refused when the pin-enable bit is 1 and `hwProtN` is low. When the pin-enable bit is 0, `hwProtN` is ignored.
- R9: From the clock edge that samples a permitted request until the edge that samples `cycleDone`, `statusOut` reads 0xFF.
- R10: The edge that samples `cycleDone` during a write ends the write and clears the latch. If the write was a status write, data bits 7, 3 and 2 are stored as the pin-enable, high and low protect bits, and the other data bits are dropped.
- R11: Every request and latch strobe is refused while a write is in progress, including in the cycle that carries `cycleDone`.
- R12: `cycleDone` with no write in progress changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| latchSet | input | 1 | Strobe: set write-enable latch |
| latchClr | input | 1 | Strobe: clear write-enable latch |
| arrayWrReq | input | 1 | Strobe: array write request |
| wrAddr | input | ADDR_W | Target byte address of the array write |
| statusWrReq | input | 1 | Strobe: status write request |
| statusWrData | input | 8 | Data byte of the status write |
| cycleDone | input | 1 | Strobe: self-timed write cycle finished |
| hwProtN | input | 1 | Hardware write-protect pin, active low |
| statusOut | output | 8 | Status value for reads |
| writePermit | output | 1 | Request accepted this cycle; front end starts the cycle |

## Verification
The done strobe and a new request or latch strobe can fall in the same cycle. The front end may issue the next command just as the timer expires. The bench provokes this in directed cases: a latch set, an array write and a status write, each on the same cycle as `cycleDone`. Random traffic that raises `cycleDone` next to other strobes provokes it as well. In each such cycle the bench expects `writePermit` low and the latch unchanged by the strobe. After the edge it expects the latch clear and `statusOut` to show the idle layout with any committed protection bits.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;

  localparam int STAT_W   = 8;
  localparam int PEN_BIT  = 7;
  localparam int PHI_BIT  = 3;
  localparam int PLO_BIT  = 2;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARRAY  = 2'd1,
    ST_STATUS = 2'd2
  } guardState_t;

  typedef struct packed {
    logic weSet;
    logic weClr;
    logic loadPend;
    logic finish;
    logic commit;
  } guardStrb_t;

endpackage

// File: rtl/status_guard_dp.sv
module status_guard_dp
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrb_t        strb,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        newNv,
  output logic              welQ,
  output logic              penQ,
  output logic              addrLocked,
  output logic [STAT_W-1:0] statusOut
);

  logic [1:0] protQ;
  logic [2:0] pendQ;
  logic [1:0] topBits;
  logic       unusedAddr;

  generate
    if (ADDR_W > 2) begin : g_wide
      assign unusedAddr = ^wrAddr[ADDR_W-3:0];
    end else begin : g_narrow
      assign unusedAddr = 1'b0;
    end
  endgenerate

  assign topBits = wrAddr[ADDR_W-1 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
    end else if (strb.finish) begin
      welQ <= 1'b0;
    end else if (strb.weClr) begin
      welQ <= 1'b0;
    end else if (strb.weSet) begin
      welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 3'b000;
    end else if (strb.loadPend) begin
      pendQ <= newNv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      penQ  <= NV_INIT[2];
      protQ <= NV_INIT[1:0];
    end else if (strb.commit) begin
      penQ  <= pendQ[2];
      protQ <= pendQ[1:0];
    end
  end

  always_comb begin
    unique case (protQ)
      2'b00:   addrLocked = 1'b0;
      2'b01:   addrLocked = (topBits == 2'b11);
      2'b10:   addrLocked = topBits[1];
      default: addrLocked = 1'b1;
    endcase
  end

  always_comb begin
    if (busyIn) begin
      statusOut = '1;
    end else begin
      statusOut           = '0;
      statusOut[PEN_BIT]  = penQ;
      statusOut[PHI_BIT]  = protQ[1];
      statusOut[PLO_BIT]  = protQ[0];
      statusOut[WEL_BIT]  = welQ;
    end
  end

  // R4
  latch_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !strb.finish) |=> $stable(welQ));

  // R10
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !welQ);

  // R10
  nv_change_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({penQ, protQ}) |-> $past(strb.commit));

endmodule

// File: rtl/status_guard_ctrl.sv
module status_guard_ctrl
  import status_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchSet,
  input  logic       latchClr,
  input  logic       arrayWrReq,
  input  logic       statusWrReq,
  input  logic       cycleDone,
  input  logic       hwProtN,
  input  logic       welIn,
  input  logic       penIn,
  input  logic       addrLocked,
  output guardStrb_t strb,
  output logic       busy,
  output logic       writePermit
);

  guardState_t stateQ, stateD;
  logic idle, arrayOk, statusOk, pinBlocks;

  assign idle      = (stateQ == ST_IDLE);
  assign busy      = !idle;
  assign pinBlocks = penIn && !hwProtN;
  assign arrayOk   = arrayWrReq && idle && welIn && !addrLocked;
  assign statusOk  = statusWrReq && idle && welIn && !pinBlocks;
  assign writePermit = arrayOk || statusOk;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (statusOk)     stateD = ST_STATUS;
        else if (arrayOk) stateD = ST_ARRAY;
      end
      ST_ARRAY, ST_STATUS: begin
        if (cycleDone) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.weSet    = latchSet && idle;
    strb.weClr    = latchClr && idle;
    strb.loadPend = statusOk;
    strb.finish   = cycleDone && !idle;
    strb.commit   = cycleDone && (stateQ == ST_STATUS);
  end

  // R9
  permit_starts_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |=> busy);

  // R6
  locked_addr_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWrReq && addrLocked) |-> !writePermit);

  // R8
  pin_blocks_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrReq && !arrayWrReq && penIn && !hwProtN) |-> !writePermit);

  // R7
  refused_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrayWrReq && !writePermit && !latchSet && !latchClr && !cycleDone)
      |=> $stable(welIn));

endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [2:0] NV_INIT = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchSet,
  input  logic              latchClr,
  input  logic              arrayWrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              statusWrReq,
  input  logic [7:0]        statusWrData,
  input  logic              cycleDone,
  input  logic              hwProtN,
  output logic [7:0]        statusOut,
  output logic              writePermit
);

  guardStrb_t strb;
  logic busy, welQ, penQ, addrLocked;
  logic [2:0] newNv;
  logic unusedData;

  assign newNv = {statusWrData[PEN_BIT], statusWrData[PHI_BIT], statusWrData[PLO_BIT]};
  assign unusedData = ^{statusWrData[6:4], statusWrData[1:0]};

  status_guard_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .latchSet    (latchSet),
    .latchClr    (latchClr),
    .arrayWrReq  (arrayWrReq),
    .statusWrReq (statusWrReq),
    .cycleDone   (cycleDone),
    .hwProtN     (hwProtN),
    .welIn       (welQ),
    .penIn       (penQ),
    .addrLocked  (addrLocked),
    .strb        (strb),
    .busy        (busy),
    .writePermit (writePermit)
  );

  status_guard_dp #(
    .ADDR_W  (ADDR_W),
    .NV_INIT (NV_INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busyIn     (busy),
    .wrAddr     (wrAddr),
    .newNv      (newNv),
    .welQ       (welQ),
    .penQ       (penQ),
    .addrLocked (addrLocked),
    .statusOut  (statusOut)
  );

endmodule

// File: tb/tb_status_guard.sv
`timescale 1ns/1ps
module tb_status_guard;

  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchSet = 0, latchClr = 0, arrayWrReq = 0, statusWrReq = 0, cycleDone = 0;
  logic hwProtN = 1;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] statusWrData = '0;
  logic [7:0] statusOut;
  logic writePermit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit mWel, mBusy, mPendStat, mPen;
  bit [1:0] mProt;
  bit [2:0] mPend;

  always #5 clk = ~clk;

  status_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .latchSet(latchSet), .latchClr(latchClr),
    .arrayWrReq(arrayWrReq), .wrAddr(wrAddr), .statusWrReq(statusWrReq),
    .statusWrData(statusWrData), .cycleDone(cycleDone), .hwProtN(hwProtN),
    .statusOut(statusOut), .writePermit(writePermit)
  );

  function automatic bit locked(bit [1:0] p, bit [AW-1:0] a);
    case (p)
      2'b00: return 1'b0;
      2'b01: return a >= 10'h300;
      2'b10: return a >= 10'h200;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] expStatus();
    if (mBusy) return 8'hFF;
    return {mPen, 3'b000, mProt, mWel, 1'b0};
  endfunction

  function automatic bit expPermit();
    if (mBusy || !mWel) return 1'b0;
    if (arrayWrReq) return !locked(mProt, wrAddr);
    if (statusWrReq) return !(mPen && !hwProtN);
    return 1'b0;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit s, bit c, bit aw, bit sw, bit [AW-1:0] a,
                     bit [7:0] d, bit done, bit pin);
    bit p;
    @(negedge clk);
    check(tag, "status", statusOut, expStatus());
    latchSet = s; latchClr = c; arrayWrReq = aw; statusWrReq = sw;
    wrAddr = a; statusWrData = d; cycleDone = done; hwProtN = pin;
    #1;
    p = expPermit();
    check(tag, "permit", {7'd0, writePermit}, {7'd0, p});
    if (mBusy) begin
      if (done) begin
        mBusy = 0; mWel = 0;
        if (mPendStat) begin mPen = mPend[2]; mProt = mPend[1:0]; end
      end
    end else begin
      if (s) mWel = 1;
      if (c) mWel = 0;
      if (p) begin
        mBusy = 1; mPendStat = sw;
        mPend = {d[7], d[3], d[2]};
      end
    end
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, '0, '0, 0, 1);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    mWel = 0; mBusy = 0; mPendStat = 0; mPen = 0; mProt = 0; mPend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    idle("R2");
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    idle("R1");
    cyc("R3", 0, 1, 0, 0, '0, '0, 0, 1);
    cyc("R5", 0, 0, 1, 0, 10'h000, '0, 0, 1);
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R8", 0, 0, 0, 1, '0, 8'h8C, 0, 0);
    idle("R9");
    cyc("R4", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R4", 0, 1, 0, 0, '0, '0, 0, 1);
    cyc("R11", 0, 0, 1, 0, 10'h010, '0, 0, 1);
    cyc("R11", 1, 0, 0, 0, '0, '0, 1, 1);
    idle("R10");
    cyc("R12", 0, 0, 0, 0, '0, '0, 1, 1);
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R6", 0, 0, 1, 0, 10'h000, '0, 0, 1);
    cyc("R7", 0, 0, 1, 0, 10'h3FF, '0, 0, 1);
    cyc("R8", 0, 0, 0, 1, '0, 8'h05, 0, 0);
    cyc("R8", 0, 0, 0, 1, '0, 8'h75, 0, 1);
    idle("R9");
    cyc("R11", 0, 0, 0, 1, '0, 8'h80, 1, 1);
    idle("R10");
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R6", 0, 0, 1, 0, 10'h300, '0, 0, 1);
    cyc("R6", 0, 0, 1, 0, 10'h2FF, '0, 0, 1);
    cyc("R11", 0, 0, 1, 0, 10'h000, '0, 1, 1);
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R8", 0, 0, 0, 1, '0, 8'h08, 0, 0);
    cyc("R10", 0, 0, 0, 0, '0, '0, 1, 1);
    cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
    cyc("R6", 0, 0, 1, 0, 10'h200, '0, 0, 1);
    cyc("R6", 0, 0, 1, 0, 10'h1FF, '0, 0, 1);
    cyc("R10", 0, 0, 0, 0, '0, '0, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      int op;
      bit [7:0] d;
      op = $urandom_range(0, 9);
      d = 8'($urandom);
      if (($urandom_range(0, 1) == 0) && (d[3:2] == 2'b11)) d[3:2] = 2'b01;
      case (op)
        0: cyc("R3", 1, 0, 0, 0, '0, '0, 0, 1);
        1: cyc("R3", 0, 1, 0, 0, '0, '0, 0, 1);
        2, 3: cyc("R5", 0, 0, 1, 0, AW'($urandom), '0, 0, 1);
        4: cyc("R8", 0, 0, 0, 1, '0, d, 0, 1'($urandom));
        5: cyc("R11", 1'($urandom), 0, 1'($urandom), 0, AW'($urandom), '0, 1, 1);
        6, 7: cyc("R10", 0, 0, 0, 0, '0, '0, 1, 1);
        default: cyc("R1", 0, 0, 0, 0, '0, '0, 0, 1'($urandom));
      endcase
    end
    idle("R1");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule